// File: doc/BRIEF.md
# Half-Duplex Collision Retry Controller

This block sequences the transmit side of a shared-medium Ethernet MAC. When the data path raises a frame request, the controller waits for the medium to be quiet and then enables transmission. While transmitting it watches for collisions. On a collision it tells the data path to send an all-ones jam, and then it drops transmit enable. It waits a randomly drawn number of slot times and then defers to the carrier again before the next attempt. A frame that keeps colliding past the programmed number of retries is dropped, and an error pulse is raised.

All timing counts a one-cycle bit-time tick, so one controller works at any line rate. The serializer reports the last bit of a frame through a strobe, and this block answers with a one-cycle frame-done pulse. Serialization, CRC and PHY signalling stay outside.

Top module: `hdx_retry_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until a request arrives, tx_en, jam_sel, frame_done and retry_err are all 0. Asserting reset during a transmission drops tx_en at once.
- R2: A request is accepted on a clock edge. With carrier low, tx_en rises after the 96th bit tick that follows that edge: a 60-tick quiet window, then a further 36-tick gap.
- R3: If carrier is asserted during the 60-tick quiet window, the window restarts from zero once carrier falls again.
- R4: Carrier asserted during the 36-tick gap that follows a completed quiet window does not delay the start of transmission.
- R5: A collision seen while transmitting raises jam_sel on the next cycle. jam_sel stays high, together with tx_en, for exactly 32 bit ticks, and then both fall.
- R6: After the n-th collision of a frame, the controller backs off for r × 512 bit ticks before deferring again (R2 timing). Here r = rand_in AND (2^k − 1), with k = min(n, 10), sampled as the jam ends.
- R7: A collision input outside transmission has no effect: no jam, and no change in deferral timing.
- R8: A last-bit strobe while transmitting, with no collision in the same cycle, drops tx_en and gives a one-cycle frame_done pulse. A collision in the same cycle takes priority and starts a jam instead.
- R9: With retry limit L (4 bits, 15 typical), a frame may be retried L times. The jam after collision number L+1 ends with tx_en low and a one-cycle retry_err pulse, and no further attempt is made.
- R10: The collision count clears after a successful frame or an abort, so the next frame draws its first backoff with k = 1.
- R11: The timers advance only on cycles where bit_tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| frame_req | input | 1 | A frame is waiting; held until done or error |
| tx_last | input | 1 | Serializer strobe: last bit of the frame sent |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| retry_limit | input | 4 | Number of retries allowed per frame |
| rand_in | input | 10 | Free-running random source |
| tx_en | output | 1 | Transmit enable |
| jam_sel | output | 1 | Data path sends all ones instead of frame data |
| frame_done | output | 1 | One-cycle pulse: frame sent |
| retry_err | output | 1 | One-cycle pulse: frame dropped after too many collisions |

## Verification
The assertions assume three things about the inputs. Carrier and collision are synchronous to clk. A request is held until frame_done or retry_err answers it. The last-bit strobe arrives only while tx_en is high and jam_sel is low. The quiet-window check also assumes that carrier low is counted only on tick cycles, the same way the timer counts it. The stimulus follows these rules: it lowers frame_req in the cycle that the answer pulse is seen, it pulses tx_last only after tx_en has been observed high, and it drives every input away from the clock edge.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEFER,
    ST_XMIT,
    ST_JAM,
    ST_BACKOFF
  } hdx_state_t;
endpackage

// File: rtl/hdx_ifg_timer.sv
module hdx_ifg_timer #(
  parameter int QUIET_BITS = 60,
  parameter int GAP_BITS   = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic crs,
  output logic in_gap,
  output logic gap_done
);
  localparam int MAXB = (QUIET_BITS > GAP_BITS) ? QUIET_BITS : GAP_BITS;
  localparam int CW   = $clog2(MAXB + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          gap_q, gap_d;

  always_comb begin
    cnt_d = cnt_q;
    gap_d = gap_q;
    if (!run) begin
      cnt_d = '0;
      gap_d = 1'b0;
    end else if (!gap_q && crs) begin
      cnt_d = '0;
    end else if (tick) begin
      if (!gap_q) begin
        if (cnt_q == CW'(QUIET_BITS - 1)) begin
          cnt_d = '0;
          gap_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (cnt_q == CW'(GAP_BITS - 1)) begin
        cnt_d = '0;
        gap_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      gap_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      gap_q <= gap_d;
    end
  end

  assign in_gap   = gap_q;
  assign gap_done = run && gap_q && tick && (cnt_q == CW'(GAP_BITS - 1));
endmodule

// File: rtl/hdx_backoff_timer.sv
module hdx_backoff_timer #(
  parameter int SLOT_BITS = 512,
  parameter int RAND_W    = 10,
  parameter int EXP_CAP   = 10,
  parameter int ATT_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              tick,
  input  logic [ATT_W-1:0]  attempt,
  input  logic [RAND_W-1:0] rand_in,
  output logic              draw_zero,
  output logic              expire
);
  localparam int BW = $clog2(SLOT_BITS);

  logic [ATT_W-1:0]  k_eff;
  logic [RAND_W-1:0] mask;
  logic [RAND_W-1:0] draw;
  logic [RAND_W-1:0] slots_q, slots_d;
  logic [BW-1:0]     bit_q, bit_d;

  always_comb begin
    k_eff = (attempt > ATT_W'(EXP_CAP)) ? ATT_W'(EXP_CAP) : attempt;
  end

  for (genvar i = 0; i < RAND_W; i++) begin : g_mask
    assign mask[i] = (k_eff > ATT_W'(i));
  end

  assign draw      = rand_in & mask;
  assign draw_zero = (draw == '0);

  always_comb begin
    slots_d = slots_q;
    bit_d   = bit_q;
    if (load) begin
      slots_d = draw;
      bit_d   = '0;
    end else if (tick && (slots_q != '0)) begin
      if (bit_q == BW'(SLOT_BITS - 1)) begin
        bit_d   = '0;
        slots_d = slots_q - 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots_q <= '0;
      bit_q   <= '0;
    end else begin
      slots_q <= slots_d;
      bit_q   <= bit_d;
    end
  end

  assign expire = tick && (bit_q == BW'(SLOT_BITS - 1)) && (slots_q == RAND_W'(1));
endmodule

// File: rtl/hdx_retry_ctrl.sv
module hdx_retry_ctrl
  import hdx_pkg::*;
#(
  parameter int QUIET_BITS = 60,
  parameter int GAP_BITS   = 36,
  parameter int JAM_BITS   = 32,
  parameter int SLOT_BITS  = 512,
  parameter int EXP_CAP    = 10,
  parameter int LIMIT_W    = 4,
  parameter int RAND_W     = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               frame_req,
  input  logic               tx_last,
  input  logic               crs,
  input  logic               col,
  input  logic [LIMIT_W-1:0] retry_limit,
  input  logic [RAND_W-1:0]  rand_in,
  output logic               tx_en,
  output logic               jam_sel,
  output logic               frame_done,
  output logic               retry_err
);
  localparam int JW    = $clog2(JAM_BITS);
  localparam int ATT_W = LIMIT_W + 1;

  logic [1:0]         rst_sync_q;
  logic               rst_i_n;
  hdx_state_t         st_q, st_d;
  logic [JW-1:0]      jam_q, jam_d;
  logic [LIMIT_W-1:0] coll_q, coll_d;
  logic               done_q, done_d;
  logic               err_q, err_d;
  logic               bo_load;
  logic               bo_zero;
  logic               bo_expire;
  logic               ifg_in_gap;
  logic               ifg_done;
  logic [ATT_W-1:0]   attempt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1] & rst_n;

  assign attempt = ATT_W'(coll_q) + 1'b1;

  hdx_ifg_timer #(
    .QUIET_BITS(QUIET_BITS),
    .GAP_BITS  (GAP_BITS)
  ) u_ifg (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .run     (st_q == ST_DEFER),
    .tick    (bit_tick),
    .crs     (crs),
    .in_gap  (ifg_in_gap),
    .gap_done(ifg_done)
  );

  hdx_backoff_timer #(
    .SLOT_BITS(SLOT_BITS),
    .RAND_W   (RAND_W),
    .EXP_CAP  (EXP_CAP),
    .ATT_W    (ATT_W)
  ) u_backoff (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (bo_load),
    .tick     (bit_tick),
    .attempt  (attempt),
    .rand_in  (rand_in),
    .draw_zero(bo_zero),
    .expire   (bo_expire)
  );

  always_comb begin
    st_d    = st_q;
    jam_d   = jam_q;
    coll_d  = coll_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    bo_load = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (frame_req) st_d = ST_DEFER;
      end
      ST_DEFER: begin
        if (ifg_done) st_d = ST_XMIT;
      end
      ST_XMIT: begin
        if (col) begin
          st_d  = ST_JAM;
          jam_d = '0;
        end else if (tx_last) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          coll_d = '0;
        end
      end
      ST_JAM: begin
        if (bit_tick) begin
          if (jam_q == JW'(JAM_BITS - 1)) begin
            jam_d = '0;
            if (coll_q == retry_limit) begin
              st_d   = ST_IDLE;
              err_d  = 1'b1;
              coll_d = '0;
            end else begin
              coll_d  = coll_q + 1'b1;
              bo_load = 1'b1;
              st_d    = bo_zero ? ST_DEFER : ST_BACKOFF;
            end
          end else begin
            jam_d = jam_q + 1'b1;
          end
        end
      end
      ST_BACKOFF: begin
        if (bo_expire) st_d = ST_DEFER;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      jam_q  <= '0;
      coll_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      jam_q  <= jam_d;
      coll_q <= coll_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign tx_en      = (st_q == ST_XMIT) || (st_q == ST_JAM);
  assign jam_sel    = (st_q == ST_JAM);
  assign frame_done = done_q;
  assign retry_err  = err_q;
endmodule

// File: rtl/hdx_retry_ctrl_chk.sv
module hdx_retry_ctrl_chk #(
  parameter int QUIET_BITS = 60
) (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic crs,
  input logic col,
  input logic tx_en,
  input logic jam_sel,
  input logic frame_done,
  input logic retry_err,
  input logic ifg_in_gap
);
  localparam int QW = $clog2(QUIET_BITS + 1);

  logic [QW-1:0] quiet_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       quiet_cnt <= '0;
    else if (crs)                                     quiet_cnt <= '0;
    else if (bit_tick && quiet_cnt != QW'(QUIET_BITS)) quiet_cnt <= quiet_cnt + 1'b1;
  end

  a_r5_jam_inside_tx: assert property (@(posedge clk) disable iff (!rst_n)
    jam_sel |-> tx_en);

  a_r5_col_starts_jam: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !jam_sel && col) |=> jam_sel);

  a_r3_quiet_before_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ifg_in_gap) |-> (quiet_cnt == QW'(QUIET_BITS)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r8_done_after_tx: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($past(tx_en && !jam_sel) && !tx_en));

  a_r9_err_after_jam: assert property (@(posedge clk) disable iff (!rst_n)
    retry_err |-> ($past(jam_sel) && !tx_en));

  a_r9_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_done, retry_err}));
endmodule

bind hdx_retry_ctrl hdx_retry_ctrl_chk #(.QUIET_BITS(QUIET_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_tick  (bit_tick),
  .crs       (crs),
  .col       (col),
  .tx_en     (tx_en),
  .jam_sel   (jam_sel),
  .frame_done(frame_done),
  .retry_err (retry_err),
  .ifg_in_gap(ifg_in_gap)
);

// File: tb/test_hdx_retry_ctrl.sv
`timescale 1ns/1ps
module test_hdx_retry_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_tick;
  logic       frame_req;
  logic       tx_last;
  logic       crs;
  logic       col;
  logic [3:0] retry_limit;
  logic [9:0] rand_in;
  logic       tx_en, jam_sel, frame_done, retry_err;
  logic       half_rate;
  int         total = 0;
  int         fails = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) bit_tick <= half_rate ? ~bit_tick : 1'b1;

  hdx_retry_ctrl i_hdx_retry_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_req(frame_req),
    .tx_last(tx_last), .crs(crs), .col(col), .retry_limit(retry_limit),
    .rand_in(rand_in), .tx_en(tx_en), .jam_sel(jam_sel),
    .frame_done(frame_done), .retry_err(retry_err)
  );

  localparam int NV = 5;
  localparam int V_LIM [NV] = '{15, 15, 0, 2, 3};
  localparam int V_NCOL[NV] = '{0, 2, 1, 3, 2};
  localparam int V_RND [NV] = '{0, 1023, 0, 0, 2};
  localparam int V_ERR [NV] = '{0, 0, 1, 1, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bo_ticks(input int n, input int rnd);
    int k = (n > 10) ? 10 : n;
    return (rnd & ((1 << k) - 1)) * 512;
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_tx(input int crs_on, input int crs_off, input int col_at,
                         output int n, output bit saw_jam);
    n = 0;
    saw_jam = 0;
    do begin
      cyc();
      n++;
      col = (n == col_at);
      if (n == crs_on)  crs = 1'b1;
      if (n == crs_off) crs = 1'b0;
      if (jam_sel) saw_jam = 1;
    end while (!tx_en && n < 5000);
    col = 1'b0;
  endtask

  task automatic finish_frame(input string req);
    tx_last = 1'b1;
    cyc();
    tx_last = 1'b0;
    chk(frame_done == 1'b1, req, int'(frame_done), 1);
    chk(tx_en == 1'b0, req, int'(tx_en), 0);
    frame_req = 1'b0;
    cyc();
    chk(frame_done == 1'b0, {req, " pulse width"}, int'(frame_done), 0);
    repeat (3) cyc();
  endtask

  task automatic count_jam(output int jl);
    jl = 0;
    while (jam_sel && jl < 100) begin
      if (!tx_en) chk(0, "R5 tx_en during jam", 0, 1);
      jl++;
      cyc();
    end
  endtask

  initial begin
    int n, jl, att;
    bit sj, aborted;
    rst_n = 1'b0; bit_tick = 1'b0; frame_req = 1'b0; tx_last = 1'b0;
    crs = 1'b0; col = 1'b0; retry_limit = 4'd15; rand_in = '0; half_rate = 1'b0;
    repeat (3) cyc();
    chk({tx_en, jam_sel, frame_done, retry_err} == 4'b0, "R1 in reset",
        int'({tx_en, jam_sel, frame_done, retry_err}), 0);
    rst_n = 1'b1;
    repeat (4) cyc();
    chk({tx_en, jam_sel, frame_done, retry_err} == 4'b0, "R1 after release",
        int'({tx_en, jam_sel, frame_done, retry_err}), 0);

    // Vector table: R2 R5 R6 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      retry_limit = 4'(V_LIM[v]);
      rand_in = 10'(V_RND[v]);
      frame_req = 1'b1;
      att = 0;
      aborted = 0;
      forever begin
        wait_tx(-1, -1, -1, n, sj);
        if (att == 0) chk(n == 97, "R2 defer time", n, 97);
        else chk(n == bo_ticks(att, V_RND[v]) + 96, "R6 backoff time", n,
                 bo_ticks(att, V_RND[v]) + 96);
        if (att < V_NCOL[v]) begin
          col = 1'b1;
          cyc();
          col = 1'b0;
          count_jam(jl);
          chk(jl == 32, "R5 jam length", jl, 32);
          att++;
          if (att == V_LIM[v] + 1) begin
            chk(retry_err == 1'b1, "R9 error pulse", int'(retry_err), 1);
            chk(tx_en == 1'b0, "R9 tx stopped", int'(tx_en), 0);
            frame_req = 1'b0;
            aborted = 1;
            cyc();
            chk(retry_err == 1'b0, "R9 pulse width", int'(retry_err), 0);
            repeat (3) cyc();
            break;
          end
        end else begin
          finish_frame("R8 frame done");
          break;
        end
      end
      chk(aborted == bit'(V_ERR[v]), "R10 frame outcome", int'(aborted), V_ERR[v]);
    end
    retry_limit = 4'd15;
    rand_in = '0;

    // R3: carrier inside quiet window restarts it
    frame_req = 1'b1;
    wait_tx(30, 35, -1, n, sj);
    chk(n == 131, "R3 quiet restart", n, 131);
    finish_frame("R3 frame done");

    // R4: carrier during the gap is ignored
    frame_req = 1'b1;
    wait_tx(70, 80, -1, n, sj);
    chk(n == 97, "R4 gap ignores carrier", n, 97);
    crs = 1'b0;
    finish_frame("R4 frame done");

    // R7: collision during deferral has no effect
    frame_req = 1'b1;
    wait_tx(-1, -1, 20, n, sj);
    chk(n == 97, "R7 defer unchanged", n, 97);
    chk(sj == 0, "R7 no jam", int'(sj), 0);
    finish_frame("R7 frame done");

    // R8: collision wins over last-bit strobe
    frame_req = 1'b1;
    wait_tx(-1, -1, -1, n, sj);
    col = 1'b1;
    tx_last = 1'b1;
    cyc();
    col = 1'b0;
    tx_last = 1'b0;
    chk(jam_sel == 1'b1, "R8 collision priority", int'(jam_sel), 1);
    chk(frame_done == 1'b0, "R8 no done on collision", int'(frame_done), 0);
    count_jam(jl);
    wait_tx(-1, -1, -1, n, sj);
    chk(n == 96, "R6 zero draw", n, 96);
    finish_frame("R8 frame done after retry");

    // R11: half-rate ticks double the deferral
    half_rate = 1'b1;
    frame_req = 1'b1;
    wait_tx(-1, -1, -1, n, sj);
    chk(n >= 192 && n <= 193, "R11 tick gating", n, 192);
    finish_frame("R11 frame done");
    half_rate = 1'b0;

    // R1: reset during transmission
    frame_req = 1'b1;
    wait_tx(-1, -1, -1, n, sj);
    frame_req = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(tx_en == 1'b0, "R1 reset drops tx_en", int'(tx_en), 0);
    cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    chk(tx_en == 1'b0, "R1 idle after reset", int'(tx_en), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule